// File: doc/BRIEF.md
# Partitioned Packed-Lane Add/Subtract Unit

This unit treats a 64-bit word as a short vector of packed integers and adds or subtracts two such words lane by lane. A two-bit lane-size control chooses eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The spare code gives one lane that spans the whole word. Carries and borrows never pass from one lane into its neighbour, so every lane behaves like a separate small adder.

Each operation either wraps modulo the lane width or saturates at the lane's numeric limits. Saturation can be signed or unsigned. The result is captured in a register when the input strobe is high. A valid flag follows the strobe one clock later. The unit fits in a pipeline stage of a datapath that processes packed media data.

Top module: `simd_addsub`

## Requirements
- R1: With `lane_sz` = 0, each 8-bit lane k (bits 8k+7..8k) is computed from only the same bits of the two operands. No carry or borrow passes between lanes.
- R2: With `lane_sz` = 1, the word forms four independent 16-bit lanes (bits 16k+15..16k).
- R3: With `lane_sz` = 2, the word forms two independent 32-bit lanes (bits 32k+31..32k).
- R4: With `lane_sz` = 3, the whole 64-bit word is one lane, and the output is always a defined value.
- R5: With `op_sub` = 0, each lane computes A+B. With `op_sub` = 1, each lane computes A−B, where A is `opa` and B is `opb`.
- R6: With `sat_en` = 0, each lane result is the exact result modulo 2 to the power of the lane width.
- R7: With `sat_en` = 1 and `sat_signed` = 1, a lane result above the lane's largest positive two's-complement value gives that value. A result below the lane's most negative value gives that value.
- R8: With `sat_en` = 1 and `sat_signed` = 0, an unsigned add that overflows gives all ones in that lane. An unsigned subtract that underflows gives zero in that lane.
- R9: `out_res` is registered. `out_vld` is high exactly one clock after `in_vld` is high. While `in_vld` is low, `out_res` keeps its value.
- R10: A synchronous active-high `rst` clears `out_res` to zero and `out_vld` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input strobe; operands are captured when high |
| op_sub | input | 1 | 0 = add, 1 = subtract (A−B) |
| lane_sz | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit lanes |
| sat_en | input | 1 | 1 = saturating, 0 = wraparound |
| sat_signed | input | 1 | 1 = signed saturation, 0 = unsigned |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_vld | output | 1 | Result valid, one clock after `in_vld` |
| out_res | output | 64 | Registered packed result |

## Verification
The bench builds the unit with its default parameters: a 64-bit word cut into 8-bit segments. This makes all four lane codes reachable, including the spare whole-word code. Random operands are mixed with directed values that sit exactly at the lane limits. These include 0x7F+1, 0x80−1, all-ones plus one and zero minus one. With them, carry-cut faults at every boundary width show up, as do clamp-direction faults in both signed and unsigned saturation.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_sz_e;

    // Number of segments forming one lane for a given size code.
    function automatic int segs_per_lane(input lane_sz_e sz, input int nseg);
        int s;
        case (sz)
            LANE_B8:  s = 1;
            LANE_B16: s = 2;
            LANE_B32: s = 4;
            default:  s = nseg;
        endcase
        if (s > nseg) s = nseg;
        return s;
    endfunction

endpackage

// File: rtl/simd_seg_add.sv
// One segment of the partitioned adder: adds A and B (B already inverted
// for subtraction) plus carry-in, reporting carry-out and signed overflow.
module simd_seg_add #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] a,
    input  logic [SEG_W-1:0] b,
    input  logic             cin,
    output logic [SEG_W-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    logic [SEG_W-1:0] low_d;
    logic             c_msb;
    logic             top_a;
    logic             top_b;

    always_comb begin
        low_d = {1'b0, a[SEG_W-2:0]} + {1'b0, b[SEG_W-2:0]} + {{(SEG_W-1){1'b0}}, cin};
        c_msb = low_d[SEG_W-1];
        top_a = a[SEG_W-1];
        top_b = b[SEG_W-1];
        sum   = {top_a ^ top_b ^ c_msb, low_d[SEG_W-2:0]};
        cout  = (top_a & top_b) | (top_a & c_msb) | (top_b & c_msb);
        ovf   = cout ^ c_msb;
    end
endmodule

// File: rtl/simd_lane_clamp.sv
// Picks the final value of one segment: the raw sum, or the saturation
// fill decided by the flags of the lane's most significant segment.
module simd_lane_clamp #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] sum,
    input  logic             is_top,
    input  logic             lane_cout,
    input  logic             lane_ovf,
    input  logic             lane_a_neg,
    input  logic             sat_en,
    input  logic             sat_signed,
    input  logic             op_sub,
    output logic [SEG_W-1:0] res
);
    localparam logic [SEG_W-1:0] ALL1 = '1;
    localparam logic [SEG_W-1:0] ALL0 = '0;
    localparam logic [SEG_W-1:0] POS_TOP = {1'b0, {(SEG_W-1){1'b1}}};
    localparam logic [SEG_W-1:0] NEG_TOP = {1'b1, {(SEG_W-1){1'b0}}};

    logic u_hit;
    logic s_hit;

    always_comb begin
        // Unsigned: an add overflows on carry-out; a subtract underflows on
        // a missing carry (borrow) out of the lane.
        u_hit = op_sub ? ~lane_cout : lane_cout;
        s_hit = lane_ovf;
        res   = sum;
        if (sat_en) begin
            if (sat_signed) begin
                if (s_hit) begin
                    if (lane_a_neg) res = is_top ? NEG_TOP : ALL0;
                    else            res = is_top ? POS_TOP : ALL1;
                end
            end else if (u_hit) begin
                res = op_sub ? ALL0 : ALL1;
            end
        end
    end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub #(
    parameter int WORD_W = 64,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              op_sub,
    input  logic [1:0]        lane_sz,
    input  logic              sat_en,
    input  logic              sat_signed,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_res
);
    import simd_pkg::*;

    localparam int NUM_SEG = WORD_W / SEG_W;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic              vld;
    } state_t;

    state_t st_d, st_q;

    lane_sz_e          sz;
    logic [WORD_W-1:0] b_eff;
    logic [NUM_SEG-1:0] seg_cin;
    logic [NUM_SEG-1:0] seg_cout;
    logic [NUM_SEG-1:0] seg_ovf;
    logic [WORD_W-1:0] sum_w;
    logic [WORD_W-1:0] res_w;

    assign sz    = lane_sz_e'(lane_sz);
    assign b_eff = op_sub ? ~opb : opb;

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        localparam int T16 = ((i | 1) < NUM_SEG) ? (i | 1) : NUM_SEG - 1;
        localparam int T32 = ((i | 3) < NUM_SEG) ? (i | 3) : NUM_SEG - 1;
        localparam int T64 = NUM_SEG - 1;

        logic is_start;
        logic is_top;
        logic l_cout;
        logic l_ovf;
        logic l_neg;

        // A segment starts a lane when its index is a multiple of the lane
        // length in segments; the carry chain is cut there.
        always_comb begin
            is_start = (i % segs_per_lane(sz, NUM_SEG)) == 0;
            is_top   = ((i + 1) % segs_per_lane(sz, NUM_SEG)) == 0;
            case (sz)
                LANE_B8: begin
                    l_cout = seg_cout[i];
                    l_ovf  = seg_ovf[i];
                    l_neg  = opa[i*SEG_W + SEG_W - 1];
                end
                LANE_B16: begin
                    l_cout = seg_cout[T16];
                    l_ovf  = seg_ovf[T16];
                    l_neg  = opa[T16*SEG_W + SEG_W - 1];
                end
                LANE_B32: begin
                    l_cout = seg_cout[T32];
                    l_ovf  = seg_ovf[T32];
                    l_neg  = opa[T32*SEG_W + SEG_W - 1];
                end
                default: begin
                    l_cout = seg_cout[T64];
                    l_ovf  = seg_ovf[T64];
                    l_neg  = opa[T64*SEG_W + SEG_W - 1];
                end
            endcase
        end

        if (i == 0) begin : g_first
            assign seg_cin[i] = op_sub;
        end else begin : g_rest
            assign seg_cin[i] = is_start ? op_sub : seg_cout[i-1];
        end

        simd_seg_add #(.SEG_W(SEG_W)) i_add (
            .a    (opa[i*SEG_W +: SEG_W]),
            .b    (b_eff[i*SEG_W +: SEG_W]),
            .cin  (seg_cin[i]),
            .sum  (sum_w[i*SEG_W +: SEG_W]),
            .cout (seg_cout[i]),
            .ovf  (seg_ovf[i])
        );

        simd_lane_clamp #(.SEG_W(SEG_W)) i_clamp (
            .sum        (sum_w[i*SEG_W +: SEG_W]),
            .is_top     (is_top),
            .lane_cout  (l_cout),
            .lane_ovf   (l_ovf),
            .lane_a_neg (l_neg),
            .sat_en     (sat_en),
            .sat_signed (sat_signed),
            .op_sub     (op_sub),
            .res        (res_w[i*SEG_W +: SEG_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) st_d.res = res_w;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_res = st_q.res;

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              op_sub,
    input logic [1:0]        lane_sz,
    input logic              sat_en,
    input logic              sat_signed,
    input logic [WORD_W-1:0] opa,
    input logic [WORD_W-1:0] opb,
    input logic              out_vld,
    input logic [WORD_W-1:0] out_res
);
    logic rst_seen_q = 1'b0;
    always_ff @(posedge clk) rst_seen_q <= rst;

    // R10
    always @(negedge clk) begin
        if (rst_seen_q) begin
            reset_clear_chk: assert (out_res == '0 && !out_vld);
        end
    end

    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R9
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(out_res)));

    // R1
    lane8_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !sat_en && !op_sub && lane_sz == 2'd0)
        |=> out_res[7:0] == 8'($past(opa[7:0]) + $past(opb[7:0])));

    // R2
    lane16_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !sat_en && !op_sub && lane_sz == 2'd1)
        |=> out_res[31:16] == 16'($past(opa[31:16]) + $past(opb[31:16])));

    // R3
    lane32_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !sat_en && !op_sub && lane_sz == 2'd2)
        |=> out_res[63:32] == 32'($past(opa[63:32]) + $past(opb[63:32])));

    // R4
    whole_word_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !sat_en && !op_sub && lane_sz == 2'd3)
        |=> out_res == $past(opa) + $past(opb));

    // R5
    whole_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !sat_en && op_sub && lane_sz == 2'd3)
        |=> out_res == $past(opa) - $past(opb));

    // R7
    sgn_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && sat_en && sat_signed && !op_sub && lane_sz == 2'd3
         && !opa[WORD_W-1] && !opb[WORD_W-1])
        |=> !out_res[WORD_W-1]);

    // R8
    uns_add_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && sat_en && !sat_signed && !op_sub && lane_sz == 2'd3)
        |=> out_res >= $past(opa));

    // R8
    uns_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && sat_en && !sat_signed && op_sub && lane_sz == 2'd3)
        |=> out_res <= $past(opa));
endmodule

bind simd_addsub simd_addsub_chk #(.WORD_W(WORD_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (in_vld),
    .op_sub     (op_sub),
    .lane_sz    (lane_sz),
    .sat_en     (sat_en),
    .sat_signed (sat_signed),
    .opa        (opa),
    .opb        (opb),
    .out_vld    (out_vld),
    .out_res    (out_res)
);

// File: tb/test_simd_addsub.sv
`timescale 1ns/1ps
module test_simd_addsub;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic        op_sub;
    logic [1:0]  lane_sz;
    logic        sat_en;
    logic        sat_signed;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        out_vld;
    logic [63:0] out_res;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    simd_addsub i_simd_addsub (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_sub(op_sub),
        .lane_sz(lane_sz), .sat_en(sat_en), .sat_signed(sat_signed),
        .opa(opa), .opb(opb), .out_vld(out_vld), .out_res(out_res)
    );

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            report();
        end
    end

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          logic sub, logic [1:0] sz,
                                          logic sat, logic sgn);
        int lw = (sz == 2'd3) ? 64 : (8 << sz);
        int nl = 64 / lw;
        logic [63:0] mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        logic [63:0] acc = '0;
        for (int k = 0; k < nl; k++) begin
            logic [63:0] xa = (a >> (k * lw)) & mask;
            logic [63:0] xb = (b >> (k * lw)) & mask;
            logic signed [65:0] va = $signed({2'b00, xa});
            logic signed [65:0] vb = $signed({2'b00, xb});
            logic signed [65:0] r, hi, lo;
            if (sgn) begin
                if (xa[lw-1]) va = va - (66'sd1 <<< lw);
                if (xb[lw-1]) vb = vb - (66'sd1 <<< lw);
                hi = (66'sd1 <<< (lw - 1)) - 66'sd1;
                lo = -(66'sd1 <<< (lw - 1));
            end else begin
                hi = (66'sd1 <<< lw) - 66'sd1;
                lo = 66'sd0;
            end
            r = sub ? (va - vb) : (va + vb);
            if (sat) begin
                if (r > hi) r = hi;
                if (r < lo) r = lo;
            end
            acc = acc | ((r[63:0] & mask) << (k * lw));
        end
        return acc;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one op at a negedge; check at the following negedge.
    task automatic do_op(string tag, logic [63:0] a, logic [63:0] b,
                         logic sub, logic [1:0] sz, logic sat, logic sgn);
        opa = a; opb = b; op_sub = sub; lane_sz = sz;
        sat_en = sat; sat_signed = sgn; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check({tag, " R9 vld"}, {63'd0, out_vld}, 64'd1);
        check(tag, out_res, model(a, b, sub, sz, sat, sgn));
    endtask

    function automatic string lane_tag(logic [1:0] sz);
        case (sz)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string mode_tag(logic sub, logic sat, logic sgn);
        string s = sub ? "R5 sub" : "R5 add";
        if (!sat)     return {s, " R6"};
        else if (sgn) return {s, " R7"};
        else          return {s, " R8"};
    endfunction

    initial begin
        logic [63:0] held;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; in_vld = 1'b0; op_sub = 1'b0; lane_sz = 2'd0;
        sat_en = 1'b0; sat_signed = 1'b0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset res", out_res, 64'd0);
        check("R10 reset vld", {63'd0, out_vld}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 wrap: every byte 0xFF+1, no carry into neighbours
        do_op("R1 R6 byte wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 2'd0, 0, 0);
        check("R1 byte wrap literal", out_res, 64'h0);
        // R1 sub borrow isolation
        do_op("R1 R5 byte borrow", 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 1, 2'd0, 0, 0);
        check("R1 R5 borrow literal", out_res, 64'h00FF_00FF_00FF_00FF);
        // R7 signed byte saturation limits
        do_op("R1 R7 pos clamp", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 0, 2'd0, 1, 1);
        check("R7 pos literal", out_res, 64'h7F7F_7F7F_7F7F_7F7F);
        do_op("R1 R7 neg clamp", 64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101, 1, 2'd0, 1, 1);
        check("R7 neg literal", out_res, 64'h8080_8080_8080_8080);
        // R8 unsigned
        do_op("R8 add all ones", 64'hFFF0_FFF0_FFF0_FFF0, 64'h0020_0020_0020_0020, 0, 2'd1, 1, 0);
        check("R2 R8 add literal", out_res, 64'hFFFF_FFFF_FFFF_FFFF);
        do_op("R8 sub zero", 64'h0000_0005_0000_0005, 64'h0000_0006_0000_0004, 1, 2'd2, 1, 0);
        check("R3 R8 sub literal", out_res, 64'h0000_0000_0000_0001);
        // R2 / R3 carry cut at lane boundary
        do_op("R2 R6 halfword wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 0, 2'd1, 0, 0);
        check("R2 halfword literal", out_res, 64'hFFFF_0000_FFFF_0000);
        do_op("R3 R6 word wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 2'd2, 0, 0);
        check("R3 word literal", out_res, 64'hFFFF_FFFF_0000_0000);
        // R4 whole word
        do_op("R4 R6 full carry", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 2'd3, 0, 0);
        check("R4 full literal", out_res, 64'h0000_0001_0000_0000);
        do_op("R4 R7 full clamp", 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0010, 0, 2'd3, 1, 1);
        check("R4 R7 full literal", out_res, 64'h7FFF_FFFF_FFFF_FFFF);

        // R9 hold: idle strobe with changed inputs leaves result alone
        held = out_res;
        opa = 64'h1234_5678_9ABC_DEF0; opb = 64'h1111_1111_1111_1111; in_vld = 1'b0;
        @(negedge clk);
        check("R9 hold res", out_res, held);
        check("R9 idle vld", {63'd0, out_vld}, 64'd0);

        // Random mix
        for (int n = 0; n < 800; n++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            logic [1:0]  sz = 2'($urandom_range(0, 3));
            logic        sub = 1'($urandom);
            logic        sat = 1'($urandom);
            logic        sgn = 1'($urandom);
            if (n % 4 == 0) b = a ^ 64'h8080_8080_8080_8080;
            do_op({lane_tag(sz), " ", mode_tag(sub, sat, sgn)}, a, b, sub, sz, sat, sgn);
        end

        // R10 reset mid-run overrides a valid strobe
        opa = 64'h5; opb = 64'h6; in_vld = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_vld = 1'b0;
        check("R10 mid reset res", out_res, 64'd0);
        check("R10 mid reset vld", {63'd0, out_vld}, 64'd0);

        done = 1'b1;
        report();
    end
endmodule